// File: doc/BRIEF.md
# Double-Buffered Divider Control Word Register

This block holds the 20-bit control word for the divider counters of a frequency synthesizer. The word carries a 9-bit main count, a 6-bit reference count, a 4-bit swallow count and a prescaler enable. A front (primary) register is loaded in one of three ways. In serial mode, bits are shifted in from a data pin under a slow serial clock pin. In parallel mode, three byte strobes each load part of the word from an 8-bit data bus. In direct mode, the counter values come straight from pins and no register is used.

A transfer strobe or a hop strobe copies the primary word into a back (secondary) register. A select input then picks which of the two words drives the counter outputs. Software can stage the next frequency in the primary register while the secondary register stays in use, then switch between them by toggling the select input.

All strobe, serial-clock and serial-data pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and edges are detected on the synchronized copy. The reset input is asserted asynchronously and released in step with the clock.

Top module: `synth_divword_reg`

## Requirements
- R1: After reset both the primary and the secondary word are all zero, so every counter output reads 0 whichever register is selected (outside direct mode).
- R2: The mode is decoded from two pins. `sel_direct` high gives direct mode whatever `sel_serial` is. `sel_direct` low with `sel_serial` high gives serial mode. Both low gives parallel mode. In direct mode the primary word never changes.
- R3: In serial mode, each rising edge of `ser_clk` shifts `ser_dat` into the primary word at bit 0, and all older bits move up one place. The first of twenty bits therefore ends at word bit 19. Word bits 19 down to 0 hold, in order: rcnt[5], rcnt[4], mcnt[8], mcnt[7], pre_en, mcnt[6..0], rcnt[3..0], scnt[3..0].
- R4: A rising edge of `xfer_wr` or of `hop_wr` copies the primary word into the secondary word. Without such an edge the secondary word holds its value.
- R5: When `use_primary` is high, the counter outputs decode the primary word. When it is low, they decode the secondary word.
- R6: In parallel mode, a rising edge of a strobe loads part of the primary word from `par_data`. `wr_hi` loads par_data[3:0] into word bits 19..16. `wr_mid` loads par_data[7:0] into bits 15..8. `wr_lo` loads par_data[7:0] into bits 7..0. The other bits keep their values.
- R7: In direct mode the outputs come from the pins. mcnt is {2'b00, pin_mcnt}, rcnt is {2'b00, pin_rcnt}, scnt is pin_scnt and pre_en is pin_pre_en. The top bits mcnt[8:7] and rcnt[5:4] always read zero.
- R8: A serial shift does not happen while `aux_sel` is high or while `xfer_wr` is held high. Parallel strobes have no effect in serial mode, and `ser_clk` edges have no effect in parallel mode.
- R9: A strobe or serial-clock pin change becomes visible at the outputs after the third rising system clock edge that follows it, and not before.
- R10: If a transfer edge and a serial shift edge are detected in the same cycle, the secondary word receives the primary word as it was before that shift, and the primary word still shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_direct | input | 1 | High selects direct mode |
| sel_serial | input | 1 | High selects serial mode when sel_direct is low |
| aux_sel | input | 1 | High routes serial bits away from this word, so no shift happens |
| ser_clk | input | 1 | Serial shift clock pin, acts on its rising edge |
| ser_dat | input | 1 | Serial data pin |
| xfer_wr | input | 1 | Transfer strobe; its rising edge copies primary to secondary |
| hop_wr | input | 1 | Hop strobe; its rising edge copies primary to secondary |
| par_data | input | 8 | Parallel data bus |
| wr_hi | input | 1 | Parallel strobe for word bits 19..16 |
| wr_mid | input | 1 | Parallel strobe for word bits 15..8 |
| wr_lo | input | 1 | Parallel strobe for word bits 7..0 |
| use_primary | input | 1 | High: outputs decode the primary word; low: the secondary word |
| pin_mcnt | input | 7 | Direct-mode main count, low 7 bits |
| pin_rcnt | input | 4 | Direct-mode reference count, low 4 bits |
| pin_scnt | input | 4 | Direct-mode swallow count |
| pin_pre_en | input | 1 | Direct-mode prescaler enable |
| cnt_mcnt | output | 9 | Main counter value |
| cnt_rcnt | output | 6 | Reference counter value |
| cnt_scnt | output | 4 | Swallow counter value |
| cnt_pre_en | output | 1 | Prescaler enable |

## Verification
The assertions assume that the mode pins, `aux_sel` and `use_primary` are quasi-static: they are not synchronized and must not change while a strobe or serial-clock edge is in flight. They also assume that `ser_dat` and `par_data` are stable for several clock cycles around each active edge. The bench changes those pins only after every strobe has fallen and the synchronizers have settled. It holds data pins for three cycles before each edge and for four cycles after it. Every pulse is held at least four system cycles high and four low, so each edge is detected exactly once.

// File: rtl/divw_pkg.sv
package divw_pkg;
  localparam int MCNT_W  = 9;
  localparam int RCNT_W  = 6;
  localparam int SCNT_W  = 4;
  localparam int MLO_W   = 7;
  localparam int RLO_W   = 4;
  localparam int MHI_W   = MCNT_W - MLO_W;
  localparam int RHI_W   = RCNT_W - RLO_W;
  localparam int WORD_W  = MCNT_W + RCNT_W + SCNT_W + 1;
  localparam int PAR_W   = 8;

  // word layout, LSB upward: scnt, rcnt low, mcnt low, pre_en, mcnt high, rcnt high
  localparam int SCNT_LSB = 0;
  localparam int RLO_LSB  = SCNT_LSB + SCNT_W;
  localparam int MLO_LSB  = RLO_LSB + RLO_W;
  localparam int PRE_POS  = MLO_LSB + MLO_W;
  localparam int MHI_LSB  = PRE_POS + 1;
  localparam int RHI_LSB  = MHI_LSB + MHI_W;

  // parallel load slices
  localparam int LO_LSB  = 0;
  localparam int MID_LSB = LO_LSB + PAR_W;
  localparam int HI_LSB  = MID_LSB + PAR_W;
  localparam int HI_W    = WORD_W - HI_LSB;

  typedef struct packed {
    logic [MCNT_W-1:0] mcnt;
    logic [RCNT_W-1:0] rcnt;
    logic [SCNT_W-1:0] scnt;
    logic              pre_en;
  } divw_fields_t;
endpackage

// File: rtl/divw_sync.sv
module divw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter bit EDGE   = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  localparam int DEPTH = STAGES + (EDGE ? 1 : 0);

  logic [DEPTH-1:0][W-1:0] chain_q;
  logic [DEPTH-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d[0] = din;
    for (int i = 1; i < DEPTH; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  generate
    if (EDGE) begin : g_rise
      assign q = chain_q[STAGES-1] & ~chain_q[STAGES];
    end else begin : g_level
      assign q = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/divw_loader.sv
module divw_loader
  import divw_pkg::*;
(
  input  logic              mode_serial,
  input  logic              mode_parallel,
  input  logic              aux_sel,
  input  logic              xfer_was_low,
  input  logic              shift_rise,
  input  logic              shift_bit,
  input  logic              hi_rise,
  input  logic              mid_rise,
  input  logic              lo_rise,
  input  logic [PAR_W-1:0]  par_data,
  input  logic [WORD_W-1:0] prim_q,
  output logic [WORD_W-1:0] prim_d
);
  logic shift_en;

  assign shift_en = mode_serial && !aux_sel && xfer_was_low && shift_rise;

  always_comb begin
    prim_d = prim_q;
    if (shift_en) prim_d = {prim_q[WORD_W-2:0], shift_bit};
    if (mode_parallel) begin
      if (hi_rise)  prim_d[HI_LSB +: HI_W]   = par_data[HI_W-1:0];
      if (mid_rise) prim_d[MID_LSB +: PAR_W] = par_data;
      if (lo_rise)  prim_d[LO_LSB +: PAR_W]  = par_data;
    end
  end
endmodule

// File: rtl/divw_unpack.sv
module divw_unpack
  import divw_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output divw_fields_t      fields
);
  always_comb begin
    fields.mcnt   = {word[MHI_LSB +: MHI_W], word[MLO_LSB +: MLO_W]};
    fields.rcnt   = {word[RHI_LSB +: RHI_W], word[RLO_LSB +: RLO_W]};
    fields.scnt   = word[SCNT_LSB +: SCNT_W];
    fields.pre_en = word[PRE_POS];
  end
endmodule

// File: rtl/synth_divword_reg.sv
module synth_divword_reg
  import divw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_direct,
  input  logic              sel_serial,
  input  logic              aux_sel,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              xfer_wr,
  input  logic              hop_wr,
  input  logic [PAR_W-1:0]  par_data,
  input  logic              wr_hi,
  input  logic              wr_mid,
  input  logic              wr_lo,
  input  logic              use_primary,
  input  logic [MLO_W-1:0]  pin_mcnt,
  input  logic [RLO_W-1:0]  pin_rcnt,
  input  logic [SCNT_W-1:0] pin_scnt,
  input  logic              pin_pre_en,
  output logic [MCNT_W-1:0] cnt_mcnt,
  output logic [RCNT_W-1:0] cnt_rcnt,
  output logic [SCNT_W-1:0] cnt_scnt,
  output logic              cnt_pre_en
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_ff;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_q = rst_ff[1];

  // mode decode
  logic mode_direct, mode_serial, mode_parallel;
  assign mode_direct   = sel_direct;
  assign mode_serial   = !sel_direct && sel_serial;
  assign mode_parallel = !sel_direct && !sel_serial;

  // level-synchronized pins: {xfer, data}
  logic [1:0] lvl;
  divw_sync #(.W(2), .STAGES(SYNC_STAGES), .EDGE(1'b0)) u_sync_lvl (
    .clk(clk), .rst_n(rst_q), .din({xfer_wr, ser_dat}), .q(lvl)
  );

  // edge-detected pins: {lo, mid, hi, hop, xfer, sclk}
  logic [5:0] rise;
  divw_sync #(.W(6), .STAGES(SYNC_STAGES), .EDGE(1'b1)) u_sync_edge (
    .clk(clk), .rst_n(rst_q),
    .din({wr_lo, wr_mid, wr_hi, hop_wr, xfer_wr, ser_clk}), .q(rise)
  );

  logic sclk_rise, xfer_rise, hop_rise, hi_rise, mid_rise, lo_rise;
  logic dat_lvl, xfer_lvl, xfer_was_low, copy_en;
  assign {lo_rise, mid_rise, hi_rise, hop_rise, xfer_rise, sclk_rise} = rise;
  assign {xfer_lvl, dat_lvl} = lvl;
  // transfer pin was low in the previous synchronized sample
  assign xfer_was_low = !xfer_lvl || xfer_rise;
  assign copy_en      = xfer_rise || hop_rise;

  // primary / secondary registers
  logic [WORD_W-1:0] prim_q, prim_d, sec_q, sec_d;

  divw_loader u_loader (
    .mode_serial(mode_serial), .mode_parallel(mode_parallel),
    .aux_sel(aux_sel), .xfer_was_low(xfer_was_low),
    .shift_rise(sclk_rise), .shift_bit(dat_lvl),
    .hi_rise(hi_rise), .mid_rise(mid_rise), .lo_rise(lo_rise),
    .par_data(par_data), .prim_q(prim_q), .prim_d(prim_d)
  );

  always_comb begin
    sec_d = sec_q;
    if (copy_en) sec_d = prim_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      prim_q <= '0;
      sec_q  <= '0;
    end else begin
      prim_q <= prim_d;
      sec_q  <= sec_d;
    end
  end

  // output selection
  divw_fields_t sel_f;
  divw_unpack u_unpack (
    .word(use_primary ? prim_q : sec_q), .fields(sel_f)
  );

  always_comb begin
    if (mode_direct) begin
      cnt_mcnt   = {{MHI_W{1'b0}}, pin_mcnt};
      cnt_rcnt   = {{RHI_W{1'b0}}, pin_rcnt};
      cnt_scnt   = pin_scnt;
      cnt_pre_en = pin_pre_en;
    end else begin
      cnt_mcnt   = sel_f.mcnt;
      cnt_rcnt   = sel_f.rcnt;
      cnt_scnt   = sel_f.scnt;
      cnt_pre_en = sel_f.pre_en;
    end
  end

  // assertions
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    !copy_en |=> $stable(sec_q)); // R4
  AST_SEC_COPY: assert property (@(posedge clk) disable iff (!rst_q)
    copy_en |=> (sec_q == $past(prim_q))); // R4
  AST_DIRECT_PRIM_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    mode_direct |=> $stable(prim_q)); // R2
  AST_DIRECT_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
    mode_direct |-> (cnt_mcnt[MCNT_W-1 -: MHI_W] == '0 && cnt_rcnt[RCNT_W-1 -: RHI_W] == '0)); // R7
  AST_AUX_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_q)
    (mode_serial && aux_sel) |=> $stable(prim_q)); // R8
endmodule

// File: tb/synth_divword_reg_bench.sv
module synth_divword_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_direct = 1'b0, sel_serial = 1'b1, aux_sel = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, xfer_wr = 1'b0, hop_wr = 1'b0;
  logic [7:0] par_data = 8'h00;
  logic wr_hi = 1'b0, wr_mid = 1'b0, wr_lo = 1'b0, use_primary = 1'b1;
  logic [6:0] pin_mcnt = '0;
  logic [3:0] pin_rcnt = '0, pin_scnt = '0;
  logic pin_pre_en = 1'b0;
  logic [8:0] cnt_mcnt;
  logic [5:0] cnt_rcnt;
  logic [3:0] cnt_scnt;
  logic cnt_pre_en;

  always #4 clk = ~clk; // 125 MHz

  synth_divword_reg u_synth_divword_reg (
    .clk(clk), .rst_n(rst_n), .sel_direct(sel_direct), .sel_serial(sel_serial),
    .aux_sel(aux_sel), .ser_clk(ser_clk), .ser_dat(ser_dat), .xfer_wr(xfer_wr),
    .hop_wr(hop_wr), .par_data(par_data), .wr_hi(wr_hi), .wr_mid(wr_mid),
    .wr_lo(wr_lo), .use_primary(use_primary), .pin_mcnt(pin_mcnt),
    .pin_rcnt(pin_rcnt), .pin_scnt(pin_scnt), .pin_pre_en(pin_pre_en),
    .cnt_mcnt(cnt_mcnt), .cnt_rcnt(cnt_rcnt), .cnt_scnt(cnt_scnt),
    .cnt_pre_en(cnt_pre_en)
  );

  typedef struct {
    logic [19:0] val; // {mcnt, rcnt, scnt, pre_en}
    string       tag;
  } item_t;

  item_t exp_q[$];
  event  chk_ev;
  int    n_chk = 0, n_fail = 0;
  logic  done = 1'b0;
  logic [19:0] m_prim = '0, m_sec = '0;

  // word layout from R3
  function automatic logic [19:0] fields_of(input logic [19:0] w);
    logic [8:0] m; logic [5:0] r; logic [3:0] s; logic p;
    r = {w[19], w[18], w[7:4]};
    m = {w[17], w[16], w[14:8]};
    p = w[15];
    s = w[3:0];
    return {m, r, s, p};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [19:0] v, input string tag);
    item_t it;
    it.val = v; it.tag = tag;
    exp_q.push_back(it);
    -> chk_ev;
    #0;
  endtask

  task automatic check_reg(input logic sel, input string tag);
    use_primary = sel;
    tick(1);
    push(fields_of(sel ? m_prim : m_sec), tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        item_t it;
        logic [19:0] act;
        it  = exp_q.pop_front();
        act = {cnt_mcnt, cnt_rcnt, cnt_scnt, cnt_pre_en};
        n_chk++;
        if (act !== it.val) begin
          n_fail++;
          $display("FAIL %s: act=%05h exp=%05h", it.tag, act, it.val);
        end
      end
    end
  end

  task automatic ser_bit(input logic b);
    ser_dat = b; tick(3);
    ser_clk = 1'b1; tick(4);
    ser_clk = 1'b0; tick(3);
  endtask

  task automatic ser_word(input logic [19:0] w);
    for (int i = 19; i >= 0; i--) ser_bit(w[i]);
  endtask

  task automatic pulse_xfer();
    xfer_wr = 1'b1; tick(4); xfer_wr = 1'b0; tick(4);
  endtask

  task automatic pulse_hop();
    hop_wr = 1'b1; tick(4); hop_wr = 1'b0; tick(4);
  endtask

  task automatic par_write(input int which, input logic [7:0] d);
    par_data = d; tick(3);
    case (which)
      0: wr_lo = 1'b1;
      1: wr_mid = 1'b1;
      default: wr_hi = 1'b1;
    endcase
    tick(4);
    wr_lo = 1'b0; wr_mid = 1'b0; wr_hi = 1'b0; tick(4);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(6);
    check_reg(1'b1, "R1 reset primary zero");
    check_reg(1'b0, "R1 reset secondary zero");

    // serial load
    ser_word(20'hA5C3E); m_prim = 20'hA5C3E;
    check_reg(1'b1, "R3 serial word in primary");
    check_reg(1'b0, "R4 secondary holds without transfer");
    pulse_xfer(); m_sec = m_prim;
    check_reg(1'b0, "R4 transfer strobe copies");
    check_reg(1'b1, "R5 primary selected");

    // aux_sel blocks shifting
    aux_sel = 1'b1; tick(2);
    ser_bit(1'b1); ser_bit(1'b0); ser_bit(1'b1);
    aux_sel = 1'b0; tick(2);
    check_reg(1'b1, "R8 no shift while aux_sel high");

    // transfer held high blocks shifting
    xfer_wr = 1'b1; tick(6);
    ser_bit(1'b1);
    xfer_wr = 1'b0; tick(4);
    check_reg(1'b1, "R8 no shift while xfer_wr high");

    // parallel mode
    sel_serial = 1'b0; tick(2);
    ser_bit(1'b1); ser_bit(1'b1);
    check_reg(1'b1, "R8 ser_clk ignored in parallel mode");
    par_write(2, 8'hF9); m_prim[19:16] = 4'h9;
    check_reg(1'b1, "R6 wr_hi loads bits 19..16");
    par_write(1, 8'h3C); m_prim[15:8] = 8'h3C;
    par_write(0, 8'h81); m_prim[7:0] = 8'h81;
    check_reg(1'b1, "R6 full parallel word");
    check_reg(1'b0, "R5 secondary still old word");
    pulse_hop(); m_sec = m_prim;
    check_reg(1'b0, "R4 hop strobe copies");

    // serial mode: parallel strobes ignored
    sel_serial = 1'b1; tick(2);
    par_write(0, 8'h55); par_write(2, 8'h06);
    check_reg(1'b1, "R8 parallel strobes ignored in serial mode");

    // latency
    use_primary = 1'b1;
    ser_dat = 1'b1; tick(3);
    ser_clk = 1'b1;
    tick(2);
    push(fields_of(m_prim), "R9 not visible after two edges");
    m_prim = {m_prim[18:0], 1'b1};
    tick(1);
    push(fields_of(m_prim), "R9 visible after third edge");
    ser_clk = 1'b0; tick(4);

    // coincident transfer and shift
    ser_dat = 1'b0; tick(3);
    ser_clk = 1'b1; xfer_wr = 1'b1;
    tick(5);
    ser_clk = 1'b0; xfer_wr = 1'b0; tick(4);
    m_sec = m_prim; m_prim = {m_prim[18:0], 1'b0};
    check_reg(1'b0, "R10 secondary gets pre-shift word");
    check_reg(1'b1, "R10 primary shifted");

    // direct mode
    sel_direct = 1'b1;
    pin_mcnt = 7'h7F; pin_rcnt = 4'hF; pin_scnt = 4'hF; pin_pre_en = 1'b1;
    tick(2);
    push({9'h07F, 6'h0F, 4'hF, 1'b1}, "R7 direct all ones, high bits zero");
    pin_mcnt = 7'h2A; pin_rcnt = 4'h5; pin_scnt = 4'hC; pin_pre_en = 1'b0;
    tick(1);
    push({9'h02A, 6'h05, 4'hC, 1'b0}, "R7 direct pattern");
    par_write(0, 8'hFF);
    ser_bit(1'b1);
    sel_serial = 1'b0; tick(2);
    par_write(1, 8'hAA);
    sel_direct = 1'b0; sel_serial = 1'b1; tick(2);
    check_reg(1'b1, "R2 primary unchanged by direct mode");

    tick(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule